// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block copies a byte range of a one-time-programmable fuse array into a destination byte buffer. After it accepts a command, it powers the fuse macro up through an ordered sequence. The sequence enables the register write mask, closes two power switches one after the other with a settle delay between them, removes isolation from the core and turns on burst-read mode. It then fetches the range one 32-bit word at a time. For each word it presents the word address with a single read strobe, polls the macro's ready flag and writes the four bytes of the word to the buffer, lowest byte first. When the range is done, or when a word read times out, it runs the power-down sequence in reverse order. It then reports completion with a one-cycle done pulse and an error code.

A configuration input given with the command skips the switch and isolation steps for macros that have no separate power domain. The write-mask and burst steps still run. The settle delay and the ready-poll limit are parameters counted in clock cycles.

Top module: `fuse_dump_seq`

## Requirements
- R1: A command whose length is non-zero but whose start address or length has either of its two low bits set finishes with err_code 1 and done in the cycle after acceptance. It changes no power output, raises no read strobe and writes no buffer byte.
- R2: A zero-length command finishes with err_code 0 and done in the cycle after acceptance, whatever its address alignment, and it does not run the power sequence.
- R3: Power-up goes through these steps, each in a different cycle: wmask_en rises, pwr_sw1 rises, pwr_sw2 rises exactly DELAY_CYC cycles after pwr_sw1, iso_en falls, and burst_en rises last.
- R4: With cmd_skip_iso set at acceptance, pwr_sw1, pwr_sw2 and iso_en never change. The only power events are wmask_en rising, burst_en rising, wmask_en falling and burst_en falling, in that order.
- R5: Power-down goes through these steps, each in a different cycle: iso_en rises, pwr_sw2 falls, pwr_sw1 falls exactly DELAY_CYC cycles after pwr_sw2, wmask_en falls, and burst_en falls last.
- R6: Each word read raises fuse_rd for exactly one cycle while burst_en is high, with fuse_addr holding the word address, and then waits for fuse_rdy.
- R7: Word addresses begin at the start address and step by 4, and exactly length/4 words are read.
- R8: Word k is written to buffer offsets 4k..4k+3, with offset 4k+i receiving fuse_data bits [8i+7:8i] (little-endian). Buffer offsets are relative to the start of the dump.
- R9: If fuse_rdy has not been seen within TIMEOUT_CYC poll cycles after the strobe, the dump stops with err_code 2. No further word is read, the power-down sequence still runs, and done follows. A ready seen on the last allowed poll cycle is accepted.
- R10: done is high for exactly one cycle per accepted command. busy stays high from acceptance until done, and cmd_start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command request, accepted when idle |
| cmd_addr | input | AW | Byte start address in the fuse array |
| cmd_len | input | AW | Byte count to dump |
| cmd_skip_iso | input | 1 | Skip power-switch and isolation steps |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 misaligned argument, 2 ready timeout |
| fuse_addr | output | AW | Word address to the fuse macro |
| fuse_rd | output | 1 | Read strobe (clears macro ready) |
| fuse_rdy | input | 1 | Macro data ready |
| fuse_data | input | 32 | Macro read data |
| wmask_en | output | 1 | Register write-mask enable |
| pwr_sw1 | output | 1 | First power switch |
| pwr_sw2 | output | 1 | Second power switch |
| iso_en | output | 1 | Isolation between fuse block and core (1 = isolated) |
| burst_en | output | 1 | Burst-read mode enable |
| buf_we | output | 1 | Buffer byte write enable |
| buf_addr | output | AW | Buffer byte offset |
| buf_data | output | 8 | Buffer byte value |

## Verification
A ready flag that arrives on the very cycle the poll counter reaches its limit hits both the word acceptance and the timeout abort at once. The design must give ready precedence. The bench sets the behavioural macro's latency first to TIMEOUT_CYC-1 and then to TIMEOUT_CYC. It expects a clean dump with correct bytes in the first case and a busy error, a single strobe and no buffer writes in the second. A second collision, a new cmd_start arriving mid-dump, is judged by the read-address log and the count of done pulses.

// File: rtl/fds_pkg.sv
package fds_pkg;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_ARG  = 2'd1,
        ERR_BUSY = 2'd2
    } fds_err_e;

    typedef enum logic [2:0] {
        T_IDLE, T_PUP, T_ISSUE, T_WAIT, T_PACK, T_PDN, T_FIN
    } fds_top_e;

    typedef enum logic [3:0] {
        PW_OFF, PW_WM, PW_UWAIT, PW_SW2, PW_ISOREL, PW_ON,
        PW_ISOSET, PW_DWAIT, PW_WMCLR, PW_BCLR
    } fds_pwr_e;

    typedef enum logic [1:0] {
        RD_IDLE, RD_STROBE, RD_POLL
    } fds_rd_e;

    function automatic logic low2_clear(input logic [1:0] v);
        return v == 2'b00;
    endfunction

    function automatic logic [7:0] le_byte(input logic [31:0] w, input logic [1:0] i);
        return w[8*i +: 8];
    endfunction

endpackage

// File: rtl/fds_power.sv
module fds_power
    import fds_pkg::*;
#(
    parameter int DELAY_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic up_req,
    input  logic dn_req,
    input  logic skip,
    output logic wmask_en,
    output logic sw1,
    output logic sw2,
    output logic iso,
    output logic burst_en,
    output logic pwr_on,
    output logic pwr_off
);
    localparam int DCW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;

    fds_pwr_e       st;
    logic [DCW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PW_OFF;
            cnt      <= '0;
            wmask_en <= 1'b0;
            sw1      <= 1'b0;
            sw2      <= 1'b0;
            iso      <= 1'b1;
            burst_en <= 1'b0;
        end else begin
            case (st)
                PW_OFF: if (up_req) begin
                    wmask_en <= 1'b1;
                    st       <= PW_WM;
                end
                PW_WM: if (skip) begin
                    burst_en <= 1'b1;
                    st       <= PW_ON;
                end else begin
                    sw1 <= 1'b1;
                    cnt <= '0;
                    st  <= PW_UWAIT;
                end
                PW_UWAIT: if (cnt == DCW'(DELAY_CYC - 1)) begin
                    sw2 <= 1'b1;
                    st  <= PW_SW2;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PW_SW2: begin
                    iso <= 1'b0;
                    st  <= PW_ISOREL;
                end
                PW_ISOREL: begin
                    burst_en <= 1'b1;
                    st       <= PW_ON;
                end
                PW_ON: if (dn_req) begin
                    if (skip) begin
                        wmask_en <= 1'b0;
                        st       <= PW_BCLR;
                    end else begin
                        iso <= 1'b1;
                        st  <= PW_ISOSET;
                    end
                end
                PW_ISOSET: begin
                    sw2 <= 1'b0;
                    cnt <= '0;
                    st  <= PW_DWAIT;
                end
                PW_DWAIT: if (cnt == DCW'(DELAY_CYC - 1)) begin
                    sw1 <= 1'b0;
                    st  <= PW_WMCLR;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PW_WMCLR: begin
                    wmask_en <= 1'b0;
                    st       <= PW_BCLR;
                end
                PW_BCLR: begin
                    burst_en <= 1'b0;
                    st       <= PW_OFF;
                end
                default: st <= PW_OFF;
            endcase
        end
    end

    assign pwr_on  = (st == PW_ON);
    assign pwr_off = (st == PW_OFF);

    AST_ISO_NEEDS_SWITCHES: assert property (@(posedge clk) disable iff (rst)
        !iso |-> (sw1 && sw2)); // R3
    AST_BURST_LAST_UP: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_en) |-> (wmask_en && (skip || !iso))); // R3
    AST_SKIP_KEEPS_SWITCHES: assert property (@(posedge clk) disable iff (rst)
        skip |-> (!sw1 && !sw2 && iso)); // R4
    AST_SW1_DROP_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(sw1) |-> (iso && !sw2)); // R5
    AST_WMASK_DROP_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(wmask_en) |-> (!sw1 && iso && burst_en)); // R5

endmodule

// File: rtl/fds_word_rd.sv
module fds_word_rd
    import fds_pkg::*;
#(
    parameter int AW          = 16,
    parameter int TIMEOUT_CYC = 50000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] addr,
    input  logic          fuse_rdy,
    input  logic [31:0]   fuse_data,
    output logic [AW-1:0] fuse_addr,
    output logic          fuse_rd,
    output logic          word_ok,
    output logic          word_to,
    output logic [31:0]   word_data
);
    localparam int TCW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

    fds_rd_e        st;
    logic [TCW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RD_IDLE;
            cnt       <= '0;
            fuse_addr <= '0;
            fuse_rd   <= 1'b0;
            word_ok   <= 1'b0;
            word_to   <= 1'b0;
            word_data <= '0;
        end else begin
            word_ok <= 1'b0;
            word_to <= 1'b0;
            case (st)
                RD_IDLE: if (go) begin
                    fuse_addr <= addr;
                    fuse_rd   <= 1'b1;
                    st        <= RD_STROBE;
                end
                RD_STROBE: begin
                    fuse_rd <= 1'b0;
                    cnt     <= '0;
                    st      <= RD_POLL;
                end
                RD_POLL: if (fuse_rdy) begin
                    word_data <= fuse_data;
                    word_ok   <= 1'b1;
                    st        <= RD_IDLE;
                end else if (cnt == TCW'(TIMEOUT_CYC - 1)) begin
                    word_to <= 1'b1;
                    st      <= RD_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fuse_rd |=> !fuse_rd); // R6
    AST_OK_TO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(word_ok && word_to)); // R9

endmodule

// File: rtl/fds_pack.sv
module fds_pack
    import fds_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [31:0]   data,
    input  logic [AW-1:0] base,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output logic          last
);
    logic          active;
    logic [1:0]    idx;
    logic [31:0]   word_q;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            word_q <= '0;
            base_q <= '0;
        end else if (load) begin
            active <= 1'b1;
            idx    <= '0;
            word_q <= data;
            base_q <= base;
        end else if (active) begin
            idx <= idx + 1'b1;
            if (idx == 2'd3) active <= 1'b0;
        end
    end

    assign we    = active;
    assign waddr = base_q + AW'(idx);
    assign wdata = le_byte(word_q, idx);
    assign last  = active && (idx == 2'd3);

    AST_WORD_STARTS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $rose(we) |-> (waddr[1:0] == 2'b00)); // R8

endmodule

// File: rtl/fuse_dump_seq.sv
module fuse_dump_seq
    import fds_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DELAY_CYC   = 50000,
    parameter int TIMEOUT_CYC = 50000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_start,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] cmd_len,
    input  logic          cmd_skip_iso,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err_code,
    output logic [AW-1:0] fuse_addr,
    output logic          fuse_rd,
    input  logic          fuse_rdy,
    input  logic [31:0]   fuse_data,
    output logic          wmask_en,
    output logic          pwr_sw1,
    output logic          pwr_sw2,
    output logic          iso_en,
    output logic          burst_en,
    output logic          buf_we,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    buf_data
);
    fds_top_e      st;
    fds_err_e      err_q;
    logic [AW-1:0] base_q, len_q, off_q;
    logic          skip_q;
    logic          pwr_on, pwr_off;
    logic          word_ok, word_to, pk_last;
    logic [31:0]   word_data;
    logic [AW:0]   off_next;

    assign off_next = {1'b0, off_q} + (AW+1)'(4);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= T_IDLE;
            err_q  <= ERR_NONE;
            base_q <= '0;
            len_q  <= '0;
            off_q  <= '0;
            skip_q <= 1'b0;
        end else begin
            case (st)
                T_IDLE: if (cmd_start) begin
                    base_q <= cmd_addr;
                    len_q  <= cmd_len;
                    skip_q <= cmd_skip_iso;
                    off_q  <= '0;
                    if (cmd_len == '0) begin
                        err_q <= ERR_NONE;
                        st    <= T_FIN;
                    end else if (!low2_clear(cmd_addr[1:0]) || !low2_clear(cmd_len[1:0])) begin
                        err_q <= ERR_ARG;
                        st    <= T_FIN;
                    end else begin
                        err_q <= ERR_NONE;
                        st    <= T_PUP;
                    end
                end
                T_PUP:   if (pwr_on) st <= T_ISSUE;
                T_ISSUE: st <= T_WAIT;
                T_WAIT: if (word_ok) begin
                    st <= T_PACK;
                end else if (word_to) begin
                    err_q <= ERR_BUSY;
                    st    <= T_PDN;
                end
                T_PACK: if (pk_last) begin
                    if (off_next >= {1'b0, len_q}) begin
                        st <= T_PDN;
                    end else begin
                        off_q <= off_next[AW-1:0];
                        st    <= T_ISSUE;
                    end
                end
                T_PDN: if (pwr_off) st <= T_FIN;
                T_FIN: st <= T_IDLE;
                default: st <= T_IDLE;
            endcase
        end
    end

    assign busy     = (st != T_IDLE);
    assign done     = (st == T_FIN);
    assign err_code = err_q;

    fds_power #(.DELAY_CYC(DELAY_CYC)) i_power (
        .clk      (clk),
        .rst      (rst),
        .up_req   (st == T_PUP),
        .dn_req   (st == T_PDN),
        .skip     (skip_q),
        .wmask_en (wmask_en),
        .sw1      (pwr_sw1),
        .sw2      (pwr_sw2),
        .iso      (iso_en),
        .burst_en (burst_en),
        .pwr_on   (pwr_on),
        .pwr_off  (pwr_off)
    );

    fds_word_rd #(.AW(AW), .TIMEOUT_CYC(TIMEOUT_CYC)) i_word_rd (
        .clk       (clk),
        .rst       (rst),
        .go        (st == T_ISSUE),
        .addr      (base_q + off_q),
        .fuse_rdy  (fuse_rdy),
        .fuse_data (fuse_data),
        .fuse_addr (fuse_addr),
        .fuse_rd   (fuse_rd),
        .word_ok   (word_ok),
        .word_to   (word_to),
        .word_data (word_data)
    );

    fds_pack #(.AW(AW)) i_pack (
        .clk   (clk),
        .rst   (rst),
        .load  ((st == T_WAIT) && word_ok),
        .data  (word_data),
        .base  (off_q),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_data),
        .last  (pk_last)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_READ_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        fuse_rd |-> burst_en); // R6
    AST_REJECT_NO_POWER: assert property (@(posedge clk) disable iff (rst)
        (done && err_q == ERR_ARG) |-> (!wmask_en && iso_en && !burst_en)); // R1
    AST_ZERO_NO_POWER: assert property (@(posedge clk) disable iff (rst)
        (done && len_q == '0) |-> (!wmask_en && !burst_en)); // R2
    AST_WRITE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> burst_en); // R8

endmodule

// File: tb/test_fuse_dump_seq.sv
`timescale 1ns/1ps
module test_fuse_dump_seq;
    localparam int AW = 16;
    localparam int DLY = 5;
    localparam int TMO = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_start = 1'b0, cmd_skip = 1'b0;
    logic [AW-1:0] cmd_addr = '0, cmd_len = '0;
    logic busy, done, fuse_rd, wmask_en, pwr_sw1, pwr_sw2, iso_en, burst_en, buf_we;
    logic [1:0] err_code;
    logic [AW-1:0] fuse_addr, buf_addr;
    logic [7:0] buf_data;
    logic fuse_rdy;
    logic [31:0] fuse_data;

    always #10 clk = ~clk;

    fuse_dump_seq #(.AW(AW), .DELAY_CYC(DLY), .TIMEOUT_CYC(TMO)) i_fuse_dump_seq (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_skip_iso(cmd_skip), .busy(busy), .done(done),
        .err_code(err_code), .fuse_addr(fuse_addr), .fuse_rd(fuse_rd),
        .fuse_rdy(fuse_rdy), .fuse_data(fuse_data), .wmask_en(wmask_en),
        .pwr_sw1(pwr_sw1), .pwr_sw2(pwr_sw2), .iso_en(iso_en), .burst_en(burst_en),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data));

    function automatic logic [31:0] fdat(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11, ~a[7:0], a[7:0] ^ 8'hC3};
    endfunction

    // behavioural fuse macro
    int lat = 3;
    bit hang = 1'b0;
    int fcnt;
    logic [AW-1:0] faddr;
    always @(posedge clk) begin
        if (rst) begin
            fuse_rdy <= 1'b0; fcnt <= 0; fuse_data <= '0; faddr <= '0;
        end else if (fuse_rd) begin
            fuse_rdy <= 1'b0; fcnt <= lat; faddr <= fuse_addr;
        end else if (fcnt != 0 && !hang) begin
            fcnt <= fcnt - 1;
            if (fcnt == 1) begin fuse_rdy <= 1'b1; fuse_data <= fdat(faddr); end
        end
    end

    // monitor
    int cyc = 0, n_ev = 0, n_rd = 0, n_we = 0, n_done = 0, dbl_done = 0, rd_bad = 0;
    int ev_code [0:63];
    int ev_cyc [0:63];
    logic [AW-1:0] rd_addr [0:63];
    logic [7:0] mem [0:255];
    logic p_wm, p_s1, p_s2, p_iso, p_bu, p_done;

    task automatic push(input int c);
        if (n_ev < 64) begin ev_code[n_ev] = c; ev_cyc[n_ev] = cyc; n_ev++; end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (wmask_en && !p_wm) push(1);
            if (pwr_sw1 && !p_s1) push(2);
            if (pwr_sw2 && !p_s2) push(3);
            if (!iso_en && p_iso) push(4);
            if (burst_en && !p_bu) push(5);
            if (iso_en && !p_iso) push(6);
            if (!pwr_sw2 && p_s2) push(7);
            if (!pwr_sw1 && p_s1) push(8);
            if (!wmask_en && p_wm) push(9);
            if (!burst_en && p_bu) push(10);
            if (fuse_rd) begin
                if (n_rd < 64) rd_addr[n_rd] = fuse_addr;
                n_rd++;
                if (!burst_en) rd_bad++;
            end
            if (buf_we) begin mem[buf_addr[7:0]] = buf_data; n_we++; end
            if (done) n_done++;
            if (done && p_done) dbl_done++;
        end
        p_wm = wmask_en; p_s1 = pwr_sw1; p_s2 = pwr_sw2; p_iso = iso_en;
        p_bu = burst_en; p_done = done;
    end

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_ev = 0; n_rd = 0; n_we = 0; n_done = 0; dbl_done = 0; rd_bad = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    logic first_done;
    logic first_busy;

    task automatic run_cmd(input int a, input int l, input bit s);
        clear_log();
        @(negedge clk);
        cmd_addr = AW'(a); cmd_len = AW'(l); cmd_skip = s; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        #1 first_done = done; first_busy = busy;
        while (n_done == 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_seq(input int n, input logic [39:0] codes, input string req);
        chk(n_ev == n, req, n_ev, n);
        for (int i = 0; i < n && i < n_ev; i++) begin
            chk(ev_code[i] == int'(codes[4*i +: 4]), req, ev_code[i], int'(codes[4*i +: 4]));
            if (i > 0) chk(ev_cyc[i] > ev_cyc[i-1], req, ev_cyc[i], ev_cyc[i-1] + 1);
        end
    endtask

    task automatic chk_data(input int a, input int words, input string req);
        for (int k = 0; k < words; k++) begin
            logic [31:0] w;
            w = fdat(AW'(a + 4*k));
            for (int i = 0; i < 4; i++)
                chk(mem[4*k+i] == w[8*i +: 8], req, mem[4*k+i], w[8*i +: 8]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!done && !busy && err_code == 2'd0, "R10 reset", {done, busy}, 0);
        chk(iso_en && !pwr_sw1 && !pwr_sw2 && !wmask_en && !burst_en, "R3 reset power", iso_en, 1);
        chk(!fuse_rd && !buf_we, "R6 reset strobe", fuse_rd, 0);
    endtask

    task automatic t_zero();
        run_cmd(3, 0, 1'b0);
        chk(first_done == 1'b1, "R2 done next cycle", first_done, 1);
        chk(err_code == 2'd0, "R2 err", err_code, 0);
        chk(n_ev == 0 && n_rd == 0 && n_we == 0, "R2 no activity", n_ev + n_rd + n_we, 0);
    endtask

    task automatic t_misalign();
        run_cmd(2, 8, 1'b0);
        chk(first_done == 1'b1, "R1 done next cycle (addr)", first_done, 1);
        chk(err_code == 2'd1, "R1 err (addr)", err_code, 1);
        chk(n_ev == 0 && n_rd == 0 && n_we == 0, "R1 no activity (addr)", n_ev + n_rd + n_we, 0);
        run_cmd(0, 6, 1'b0);
        chk(err_code == 2'd1, "R1 err (len)", err_code, 1);
        chk(n_ev == 0 && n_rd == 0, "R1 no activity (len)", n_ev + n_rd, 0);
    endtask

    task automatic t_normal();
        lat = 3; hang = 1'b0;
        run_cmd(16, 12, 1'b0);
        chk(first_busy == 1'b1 && first_done == 1'b0, "R10 busy after accept", first_busy, 1);
        chk(err_code == 2'd0, "R7 err", err_code, 0);
        chk_seq(10, 40'hA987654321, "R3 R5 order");
        if (n_ev == 10) begin
            chk(ev_cyc[2] - ev_cyc[1] == DLY, "R3 settle delay", ev_cyc[2] - ev_cyc[1], DLY);
            chk(ev_cyc[7] - ev_cyc[6] == DLY, "R5 settle delay", ev_cyc[7] - ev_cyc[6], DLY);
        end
        chk(n_rd == 3, "R7 word count", n_rd, 3);
        for (int k = 0; k < 3 && k < n_rd; k++)
            chk(rd_addr[k] == AW'(16 + 4*k), "R7 word address", rd_addr[k], 16 + 4*k);
        chk(rd_bad == 0, "R6 strobe outside burst", rd_bad, 0);
        chk(n_we == 12, "R8 byte count", n_we, 12);
        chk_data(16, 3, "R8 byte order");
        chk(n_done == 1 && dbl_done == 0, "R10 done pulse", n_done, 1);
    endtask

    task automatic t_skip();
        lat = 2;
        run_cmd(64, 8, 1'b1);
        chk_seq(4, 40'h0000000A951, "R4 skip events");
        chk(err_code == 2'd0 && n_rd == 2, "R4 reads", n_rd, 2);
        chk_data(64, 2, "R4 data");
    endtask

    task automatic t_busy_ignore();
        lat = 4;
        clear_log();
        @(negedge clk);
        cmd_addr = 16'h20; cmd_len = 16'd8; cmd_skip = 1'b0; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        repeat (3) @(negedge clk);
        cmd_addr = 16'h80; cmd_len = 16'd4; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        while (n_done == 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(n_rd == 2, "R10 ignored cmd reads", n_rd, 2);
        chk(rd_addr[1] == 16'h24, "R10 ignored cmd addr", rd_addr[1], 16'h24);
        chk(n_done == 1 && !busy, "R10 no queued cmd", n_done, 1);
    endtask

    task automatic t_timeout();
        hang = 1'b1;
        run_cmd(64, 8, 1'b0);
        hang = 1'b0;
        chk(err_code == 2'd2, "R9 busy error", err_code, 2);
        chk(n_rd == 1 && n_we == 0, "R9 stops reading", n_rd, 1);
        chk_seq(10, 40'hA987654321, "R9 power down after abort");
        chk(n_done == 1, "R9 done", n_done, 1);
    endtask

    task automatic t_edge();
        lat = TMO - 1;
        run_cmd(8, 4, 1'b0);
        chk(err_code == 2'd0 && n_we == 4, "R9 ready on last poll", err_code, 0);
        chk_data(8, 1, "R9 last-poll data");
        lat = TMO;
        run_cmd(8, 4, 1'b0);
        chk(err_code == 2'd2 && n_we == 0, "R9 ready one poll late", err_code, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_zero();
        t_misalign();
        t_normal();
        t_skip();
        t_busy_ignore();
        t_timeout();
        t_edge();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule